// File: doc/BRIEF.md
# Column Post-Processing Pipeline

This block sits under the columns of a matrix-multiply array and handles the values each column emits. One row of column results enters per cycle. Every lane carries one column through four registered stages in a fixed order: a per-column offset add, a leaky rectifier with a programmable slope, a mean-squared-error gradient against a per-column target, and a rectifier-derivative multiply. The derivative stage draws on activations the unit stored during an earlier forward pass.

A four-bit stage-enable word travels with each row and selects which stages compute on it. A stage that is not enabled copies its input into its register, so every row leaves exactly four cycles after it entered. A hidden layer's forward pass enables the offset and rectifier. The final layer also enables the gradient stage. The backward chain enables only the derivative stage. Each lane keeps a small cache of rectifier outputs, one slot per batch row, so that gradients can be scaled later without a trip to main memory.

Values are signed fixed point with `FRAC` fraction bits. Additions wrap modulo 2^DW. Products are shifted right arithmetically, which rounds toward minus infinity, and then truncated to DW bits.

Top module: `vpp_top`

## Requirements
- R1: After reset, out_valid is 0 and out_data is all zeros until the first valid row has had time to reach the output.
- R2: out_valid equals in_valid from exactly four rising edges earlier, whatever the stage-enable word is.
- R3: With in_path = 4'b0000, each lane's output equals its input from four edges earlier.
- R4: in_path bit 0 enables the offset stage, which adds the lane's lane_bias slice to the value and wraps modulo 2^DW.
- R5: in_path bit 1 enables the rectifier. A value greater than zero passes unchanged. Any other value v becomes (v * leak_factor) >>> FRAC, with leak_factor in Q(DW-FRAC).FRAC (128 = 0.5 at the defaults).
- R6: in_path bit 2 enables the loss-gradient stage, which outputs (v - target) * 2 / BATCH, computed as (v - target) >>> (log2(BATCH) - 1) on DW+1 bits and truncated to DW bits.
- R7: Every valid row that passes an enabled rectifier stores its rectifier output, per lane, in cache slot k. The slot index k starts at 0 and steps through 0..BATCH-1 cyclically. Valid rows with the derivative stage enabled read the slots in the same cyclic order, starting at 0.
- R8: in_path bit 3 enables the derivative stage. If the cached activation is greater than zero, the incoming gradient passes unchanged. Otherwise it becomes (g * leak_factor) >>> FRAC.
- R9: When several stages are enabled, they apply in the order offset, rectifier, loss, derivative.
- R10: The stage-enable word is captured with its own row. Changing in_path between back-to-back rows changes only the row it was presented with.
- R11: Cycles with in_valid low produce out_valid low four cycles later and do not advance either cache slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A row of column values is present |
| in_path | input | 4 | Stage enables: bit0 offset, bit1 rectifier, bit2 loss, bit3 derivative |
| in_data | input | LANES*DW | One signed value per lane, lane 0 in the low bits |
| lane_bias | input | LANES*DW | Per-lane offset, held while rows are in flight |
| leak_factor | input | DW | Negative-side slope in fixed point, shared by all lanes |
| lane_target | input | LANES*DW | Per-lane target value for the loss-gradient stage |
| out_valid | output | 1 | out_data holds a processed row |
| out_data | output | LANES*DW | Processed row, lane 0 in the low bits |

## Verification
The bound checker tests on every cycle the properties that need no arithmetic model: the four-cycle valid delay, the clean output after reset, the identity when every stage is bypassed, and the rectifier passing positive inputs unchanged. The arithmetic of the offset, slope, loss and derivative stages needs the bench's scenarios, as does every combination of enables. So does the cached-activation order, which shows only when a series of forward rows is followed by backward rows. The bench also streams back-to-back rows with mixed enables and gaps to show that each row keeps its own enable word.

// File: rtl/vpp_pkg.sv
package vpp_pkg;

    localparam int NSTAGE = 4;

    // Stage positions; the value is also the enable bit index in the path word.
    typedef enum logic [1:0] {
        STG_BIAS = 2'd0,
        STG_ACT  = 2'd1,
        STG_LOSS = 2'd2,
        STG_DACT = 2'd3
    } stage_e;

    // Packed so that bias lands in bit 0 and dact in bit 3.
    typedef struct packed {
        logic dact;
        logic loss;
        logic act;
        logic bias;
    } path_t;

    typedef struct packed {
        logic  vld;
        path_t path;
    } ctrl_t;

    function automatic logic stage_on(input ctrl_t c, input stage_e s);
        logic [NSTAGE-1:0] bits;
        bits = c.path;
        return bits[s];
    endfunction

endpackage

// File: rtl/vpp_ctrl_pipe.sv
module vpp_ctrl_pipe
    import vpp_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDXW  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  ctrl_t                  in_ctrl,
    output ctrl_t [NSTAGE-2:0]     stg_q,
    output logic                   out_vld,
    output logic                   wr_en,
    output logic [IDXW-1:0]        wr_idx,
    output logic [IDXW-1:0]        rd_idx
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);

    logic rd_step;

    // Control tokens follow their row stage by stage.
    for (genvar g = 0; g < NSTAGE - 1; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg_q[g] <= '0;
                else     stg_q[g] <= in_ctrl;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stg_q[g] <= '0;
                else     stg_q[g] <= stg_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= stg_q[NSTAGE-2].vld;
    end

    // The rectifier result is registered at the edge that loads stage 1.
    assign wr_en   = stg_q[0].vld && stage_on(stg_q[0], STG_ACT);
    // The derivative result is registered at the edge that loads stage 3.
    assign rd_step = stg_q[2].vld && stage_on(stg_q[2], STG_DACT);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (wr_en)   wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            if (rd_step) rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
        end
    end

endmodule

// File: rtl/vpp_act_cache.sv
module vpp_act_cache #(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    parameter int IDXW  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic signed [DW-1:0] wr_data,
    input  logic [IDXW-1:0]      rd_idx,
    output logic signed [DW-1:0] rd_data
);

    logic signed [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/vpp_lane.sv
module vpp_lane
    import vpp_pkg::*;
#(
    parameter int DW         = 16,
    parameter int FRAC       = 8,
    parameter int LOSS_SHIFT = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  ctrl_t [NSTAGE-1:0]     ctrl_in,
    input  logic signed [DW-1:0]   din,
    input  logic signed [DW-1:0]   bias,
    input  logic signed [DW-1:0]   leak,
    input  logic signed [DW-1:0]   target,
    input  logic signed [DW-1:0]   cache_rd,
    output logic signed [DW-1:0]   act_wdata,
    output logic signed [DW-1:0]   dout
);

    logic signed [DW-1:0] stage_q [NSTAGE];
    logic signed [DW-1:0] stage_nx [NSTAGE];
    logic signed [DW:0]   diff;
    logic signed [DW:0]   diff_sh;

    function automatic logic is_pos(input logic signed [DW-1:0] v);
        return !v[DW-1] && (v != '0);
    endfunction

    function automatic logic signed [DW-1:0] slope_mul(input logic signed [DW-1:0] v,
                                                      input logic signed [DW-1:0] k);
        logic signed [2*DW-1:0] p;
        p = v * k;
        return p[FRAC+DW-1:FRAC];
    endfunction

    always_comb begin
        stage_nx[STG_BIAS] = stage_on(ctrl_in[STG_BIAS], STG_BIAS) ? din + bias : din;

        if (stage_on(ctrl_in[STG_ACT], STG_ACT))
            stage_nx[STG_ACT] = is_pos(stage_q[0]) ? stage_q[0] : slope_mul(stage_q[0], leak);
        else
            stage_nx[STG_ACT] = stage_q[0];

        diff    = stage_q[1] - target;
        diff_sh = diff >>> LOSS_SHIFT;
        stage_nx[STG_LOSS] = stage_on(ctrl_in[STG_LOSS], STG_LOSS) ? diff_sh[DW-1:0] : stage_q[1];

        if (stage_on(ctrl_in[STG_DACT], STG_DACT))
            stage_nx[STG_DACT] = is_pos(cache_rd) ? stage_q[2] : slope_mul(stage_q[2], leak);
        else
            stage_nx[STG_DACT] = stage_q[2];
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= stage_nx[g];
        end
    end

    assign act_wdata = stage_nx[STG_ACT];
    assign dout      = stage_q[NSTAGE-1];

endmodule

// File: rtl/vpp_top.sv
module vpp_top
    import vpp_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DW    = 16,
    parameter int FRAC  = 8,
    parameter int BATCH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [3:0]            in_path,
    input  logic [LANES*DW-1:0]   in_data,
    input  logic [LANES*DW-1:0]   lane_bias,
    input  logic [DW-1:0]         leak_factor,
    input  logic [LANES*DW-1:0]   lane_target,
    output logic                  out_valid,
    output logic [LANES*DW-1:0]   out_data
);

    localparam int BATCH_LOG2 = (BATCH > 1) ? $clog2(BATCH) : 1;
    localparam int LOSS_SHIFT = BATCH_LOG2 - 1;
    localparam int IDXW       = (BATCH > 1) ? $clog2(BATCH) : 1;

    ctrl_t                in_ctrl;
    ctrl_t [NSTAGE-2:0]   stg_q;
    ctrl_t [NSTAGE-1:0]   gov;
    logic                 wr_en;
    logic [IDXW-1:0]      wr_idx;
    logic [IDXW-1:0]      rd_idx;

    assign in_ctrl.vld  = in_valid;
    assign in_ctrl.path = path_t'(in_path);
    // Stage k computes under the token of the row sitting in front of it.
    assign gov = {stg_q, in_ctrl};

    vpp_ctrl_pipe #(
        .DEPTH (BATCH),
        .IDXW  (IDXW)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_ctrl (in_ctrl),
        .stg_q   (stg_q),
        .out_vld (out_valid),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .rd_idx  (rd_idx)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic signed [DW-1:0] act_w;
        logic signed [DW-1:0] act_r;
        logic signed [DW-1:0] res;

        vpp_act_cache #(
            .DW    (DW),
            .DEPTH (BATCH),
            .IDXW  (IDXW)
        ) u_cache (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_data (act_w),
            .rd_idx  (rd_idx),
            .rd_data (act_r)
        );

        vpp_lane #(
            .DW         (DW),
            .FRAC       (FRAC),
            .LOSS_SHIFT (LOSS_SHIFT)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .ctrl_in   (gov),
            .din       ($signed(in_data[l*DW +: DW])),
            .bias      ($signed(lane_bias[l*DW +: DW])),
            .leak      ($signed(leak_factor)),
            .target    ($signed(lane_target[l*DW +: DW])),
            .cache_rd  (act_r),
            .act_wdata (act_w),
            .dout      (res)
        );

        assign out_data[l*DW +: DW] = res;
    end

endmodule

// File: rtl/vpp_top_chk.sv
module vpp_top_chk #(
    parameter int LANES = 2,
    parameter int DW    = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [3:0]          in_path,
    input logic [LANES*DW-1:0] in_data,
    input logic                out_valid,
    input logic [LANES*DW-1:0] out_data
);

    // Edges seen since reset was released, saturating.
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd0) |-> (!out_valid && out_data == '0));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R3
    bypass_ident_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && $past(in_valid, 4) && $past(in_path, 4) == 4'b0000)
        |-> (out_data == $past(in_data, 4)));

    // R5
    rect_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && $past(in_valid, 4) && $past(in_path, 4) == 4'b0010
         && !$past(in_data[DW-1], 4) && $past(in_data[DW-1:0], 4) != '0)
        |-> (out_data[DW-1:0] == $past(in_data[DW-1:0], 4)));

endmodule

bind vpp_top vpp_top_chk #(
    .LANES (LANES),
    .DW    (DW)
) u_vpp_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_path   (in_path),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/vpp_top_test.sv
`timescale 1ns/1ps
module vpp_top_test;

    localparam int LANES = 2;
    localparam int DW    = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [3:0]          in_path = '0;
    logic [LANES*DW-1:0] in_data = '0;
    logic [LANES*DW-1:0] lane_bias = '0;
    logic [DW-1:0]       leak_factor = '0;
    logic [LANES*DW-1:0] lane_target = '0;
    logic                out_valid;
    logic [LANES*DW-1:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model of the activation cache and its slot indices (R7).
    longint cache_m [LANES][4];
    int     wp = 0;
    int     rp = 0;

    always #4 clk = ~clk;

    vpp_top uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_path     (in_path),
        .in_data     (in_data),
        .lane_bias   (lane_bias),
        .leak_factor (leak_factor),
        .lane_target (lane_target),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic longint wrap(input longint v);
        logic [15:0] t;
        t = v[15:0];
        return longint'($signed(t));
    endfunction

    // Expected row for the requirements, updating the cache model in row order.
    task automatic model_row(input logic [3:0] p, input logic [31:0] x, output logic [31:0] e);
        for (int l = 0; l < LANES; l++) begin
            longint v, b, t, k, a;
            logic [15:0] tmp;
            v = longint'($signed(x[l*16 +: 16]));
            b = longint'($signed(lane_bias[l*16 +: 16]));
            t = longint'($signed(lane_target[l*16 +: 16]));
            k = longint'($signed(leak_factor));
            if (p[0]) v = wrap(v + b);                               // R4
            if (p[1]) begin                                          // R5
                if (v <= 0) v = wrap((v * k) >>> 8);
                cache_m[l][wp] = v;                                  // R7
            end
            if (p[2]) v = wrap((v - t) >>> 1);                       // R6, BATCH 4
            if (p[3]) begin                                          // R8
                a = cache_m[l][rp];
                if (a <= 0) v = wrap((v * k) >>> 8);
            end
            tmp = v[15:0];
            e[l*16 +: 16] = tmp;
        end
        if (p[1]) wp = (wp + 1) % 4;
        if (p[3]) rp = (rp + 1) % 4;
    endtask

    function automatic string tag_of(input logic [3:0] p);
        case (p)
            4'b0000: return "R3";
            4'b0001: return "R4";
            4'b0010: return "R5";
            4'b0100: return "R6";
            4'b1000: return "R8";
            default: return "R9";
        endcase
    endfunction

    // One isolated row: drive at a falling edge, observe after the 3rd and 4th rising edges.
    task automatic run_row(input logic [3:0] p, input logic [31:0] x, input string req);
        logic [31:0] e;
        model_row(p, x, e);
        in_valid = 1'b1;
        in_path  = p;
        in_data  = x;
        @(negedge clk);
        in_valid = 1'b0;
        in_path  = 4'hF;
        in_data  = 32'hDEAD_BEEF;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 early", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R2", {31'd0, out_valid}, 32'd1);
        check(out_data == e, req, out_data, e);
    endtask

    function automatic logic [31:0] pack2(input int a, input int b);
        logic [15:0] ha, hb;
        ha = a[15:0];
        hb = b[15:0];
        return {hb, ha};
    endfunction

    initial begin
        int vals0 [6] = '{-1000, -3, 0, 1, 77, 12000};
        int vals1 [6] = '{500, -20000, 9, -1, 0, 256};
        int leaks [2] = '{128, 26};

        for (int l = 0; l < LANES; l++)
            for (int s = 0; s < 4; s++) cache_m[l][s] = 0;

        repeat (3) @(negedge clk);
        // R1: outputs clear under and just after reset
        check(out_valid == 1'b0 && out_data == '0, "R1", out_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1", out_data, 32'd0);

        lane_bias   = pack2(300, -50);
        lane_target = pack2(256, -128);
        leak_factor = 16'd128;

        // R3: all stages bypassed
        run_row(4'b0000, pack2(-7, 32767), "R3");
        // R4: wrap on overflow
        run_row(4'b0001, pack2(32700, -32760), "R4");

        // R7: four forward rows fill slots 0..3, then backward rows read them in order
        run_row(4'b0010, pack2(-100, 40), "R7");
        run_row(4'b0010, pack2(60, -10), "R7");
        run_row(4'b0010, pack2(0, 5), "R7");
        run_row(4'b0010, pack2(3, -1), "R7");
        for (int i = 0; i < 4; i++) run_row(4'b1000, pack2(1000, -800), "R7");

        // R9 and single stages: sweep every enable word, several values and two slopes
        foreach (leaks[li]) begin
            leak_factor = leaks[li][15:0];
            for (int p = 0; p < 16; p++)
                for (int v = 0; v < 6; v++)
                    run_row(p[3:0], pack2(vals0[v], vals1[(v + p) % 6]), tag_of(p[3:0]));
        end
        leak_factor = 16'd128;

        // R10, R11: back-to-back rows with gaps and changing enables
        begin
            logic        sv [10];
            logic [3:0]  sp [10];
            logic [31:0] sx [10];
            logic [31:0] se [10];
            logic [3:0]  plist [5] = '{4'b0000, 4'b0001, 4'b0100, 4'b0101, 4'b1000};
            for (int j = 0; j < 10; j++) begin
                sv[j] = (j % 4) != 2;
                sp[j] = plist[j % 5];
                sx[j] = pack2(j * 97 - 400, 300 - j * 211);
                if (sv[j]) model_row(sp[j], sx[j], se[j]);
                else       se[j] = '0;
            end
            for (int j = 0; j < 14; j++) begin
                if (j < 10) begin
                    in_valid = sv[j];
                    in_path  = sp[j];
                    in_data  = sx[j];
                end else begin
                    in_valid = 1'b0;
                    in_path  = 4'hF;
                    in_data  = '0;
                end
                if (j >= 4) begin
                    check(out_valid == sv[j-4], "R11", {31'd0, out_valid}, {31'd0, sv[j-4]});
                    if (sv[j-4]) check(out_data == se[j-4], "R10", out_data, se[j-4]);
                end
                @(negedge clk);
            end
            in_valid = 1'b0;
        end

        // R11: idle gaps did not move the slot indices; next backward row reads the modelled slot
        run_row(4'b1000, pack2(-640, 640), "R11");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule